// File: doc/BRIEF.md
# Cache Line Refill Controller with Critical-Word Return

This block handles a cache read miss by bringing the whole four-word line in from the next memory level. Each miss carries the line address, the offset of the word the processor is waiting for, and a one-bit policy select. With wrap ordering chosen, the waiting word is asked for first. The remaining words follow in ascending order and wrap around the line. With linear ordering chosen, the words are asked for from word 0 upward. Under either policy, the waiting word goes to the processor as soon as its response comes in. The line then keeps filling in the background.

Every returned word is written into the cache data array at its own word position. After the fourth write, the controller pulses a completion strobe that also acts as the line's valid-bit write. The controller takes one miss at a time and uses a ready signal to hold off a new miss until the current line is complete. Tag storage and victim selection belong to the surrounding cache.

Top module: `line_refill_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, miss_ready is 1 and mem_req_valid, arr_we, cpu_valid and fill_done are all 0.
- R2: Each accepted miss produces exactly four memory requests, one for each word of the line. Request address = {line address, 2-bit word offset}, with the word offset in bits [1:0]. No request is issued while the controller is idle.
- R3: When miss_crit_first=1, the k-th request (k = 0..3) has word offset (miss_ofs + k) mod 4.
- R4: When miss_crit_first=0, the k-th request has word offset k, so words are requested in the order 0, 1, 2, 3.
- R5: Responses come back in request order. A response accepted at a clock edge appears as one arr_we pulse in the next cycle. That pulse carries the word offset of the matching request on arr_ofs, the miss line address on arr_blk, and the response data on arr_wdata.
- R6: The cycle after the response for the missed word arrives, cpu_valid is high for exactly one cycle and cpu_data holds that word. The other words of the line never assert cpu_valid.
- R7: fill_done pulses for one cycle, in the cycle after the fourth array write, with the miss line address on fill_blk. It is the line's valid-bit write.
- R8: miss_ready goes low in the cycle after a miss is accepted and returns high in the fill_done cycle. A miss_valid seen while miss_ready is low has no effect on the requests or writes of the current line.
- R9: A request whose mem_req_ready is low stays valid with an unchanged address in the next cycle. Any number of idle cycles between responses is tolerated.
- R10: A mem_rsp_valid seen while the controller is idle causes no array write and no processor return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Controller idle and able to take a miss |
| miss_blk | input | BLK_W | Line address of the miss |
| miss_ofs | input | 2 | Offset of the word the processor waits for |
| miss_crit_first | input | 1 | 1: wrap ordering from the missed word, 0: linear from word 0 |
| mem_req_valid | output | 1 | Word request to memory |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | BLK_W+2 | Word address {line, offset} |
| mem_rsp_valid | input | 1 | Memory returns one word |
| mem_rsp_data | input | DATA_W | Returned word |
| arr_we | output | 1 | Data array word write strobe |
| arr_blk | output | BLK_W | Line address for the array write |
| arr_ofs | output | 2 | Word position for the array write |
| arr_wdata | output | DATA_W | Word to write |
| cpu_valid | output | 1 | Missed word returned to the processor |
| cpu_data | output | DATA_W | Missed word |
| fill_done | output | 1 | Line complete and valid-bit write strobe |
| fill_blk | output | BLK_W | Line address for the valid-bit write |

## Verification
The first request is visible one cycle after the miss is accepted. A response accepted at an edge produces its array write, and when it carries the missed word also its processor return, in the following cycle. The completion strobe comes one cycle after the fourth write, and ready rises in that same cycle. The bench drives inputs and samples outputs on the falling edge. Whatever it drives at one falling edge sets the flags it expects to see at the next falling edge, so every comparison lands exactly one register stage after its cause. The memory model picks request acceptance and response gaps at random, and the missed-word responses, wrap-around corners and idle-time stray responses are covered by directed misses.

// File: rtl/refill_pkg.sv
package refill_pkg;

  // order in which the words of a line are fetched
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_WRAP   = 1'b1
  } fill_order_e;

endpackage

// File: rtl/refill_order.sv
// Maps the k-th transfer of a line to its word position.
module refill_order
  import refill_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  fill_order_e        policy,
  input  logic [OFS_W-1:0]   crit,
  input  logic [OFS_W-1:0]   step,
  output logic [OFS_W-1:0]   word
);

  // the offset width is log2 of the line size, so the add wraps modulo the line
  always_comb begin
    if (policy == ORDER_WRAP) word = crit + step;
    else                      word = step;
  end

endmodule

// File: rtl/refill_issue.sv
// Issues the word requests of one line, holding each until memory takes it.
module refill_issue
  import refill_pkg::*;
#(
  parameter int BLK_W = 28,
  parameter int WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [BLK_W-1:0]              blk,
  input  logic [$clog2(WORDS)-1:0]      crit,
  input  fill_order_e                   policy,
  input  logic                          req_ready,
  output logic                          req_valid,
  output logic [BLK_W+$clog2(WORDS)-1:0] req_addr
);

  localparam int OFS_W = $clog2(WORDS);
  localparam logic [OFS_W-1:0] LAST = OFS_W'(WORDS - 1);

  logic [OFS_W-1:0] step_q;
  logic [BLK_W-1:0] blk_q;
  logic [OFS_W-1:0] crit_q;
  fill_order_e      pol_q;
  logic             valid_q;
  logic [BLK_W+OFS_W-1:0] addr_q;

  logic             take;
  fill_order_e      sel_pol;
  logic [OFS_W-1:0] sel_crit;
  logic [OFS_W-1:0] sel_step;
  logic [BLK_W-1:0] sel_blk;
  logic [OFS_W-1:0] next_word;

  assign take = valid_q & req_ready;

  // one order unit serves both the first word of a line and every later one
  always_comb begin
    if (start) begin
      sel_pol  = policy;
      sel_crit = crit;
      sel_step = '0;
      sel_blk  = blk;
    end else begin
      sel_pol  = pol_q;
      sel_crit = crit_q;
      sel_step = step_q + 1'b1;
      sel_blk  = blk_q;
    end
  end

  refill_order #(.OFS_W(OFS_W)) u_order (
    .policy (sel_pol),
    .crit   (sel_crit),
    .step   (sel_step),
    .word   (next_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      step_q  <= '0;
    end else if (start) begin
      valid_q <= 1'b1;
      step_q  <= '0;
    end else if (take) begin
      if (step_q == LAST) valid_q <= 1'b0;
      step_q <= step_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      blk_q  <= blk;
      crit_q <= crit;
      pol_q  <= policy;
      addr_q <= {sel_blk, next_word};
    end else if (take && step_q != LAST) begin
      addr_q <= {sel_blk, next_word};
    end
  end

  assign req_valid = valid_q;
  assign req_addr  = addr_q;

endmodule

// File: rtl/refill_collect.sv
// Places returning words into the data array and forwards the missed one.
module refill_collect
  import refill_pkg::*;
#(
  parameter int BLK_W  = 28,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [BLK_W-1:0]          blk,
  input  logic [$clog2(WORDS)-1:0]  crit,
  input  fill_order_e               policy,
  input  logic                      rsp_valid,
  input  logic [DATA_W-1:0]         rsp_data,
  output logic                      wr_en,
  output logic [BLK_W-1:0]          wr_blk,
  output logic [$clog2(WORDS)-1:0]  wr_ofs,
  output logic [DATA_W-1:0]         wr_data,
  output logic                      fwd_valid,
  output logic [DATA_W-1:0]         fwd_data,
  output logic                      last_wr
);

  localparam int OFS_W = $clog2(WORDS);
  localparam logic [OFS_W-1:0] LAST = OFS_W'(WORDS - 1);

  logic             active_q;
  logic [OFS_W-1:0] step_q;
  logic [BLK_W-1:0] blk_q;
  logic [OFS_W-1:0] crit_q;
  fill_order_e      pol_q;
  logic             we_q;
  logic             fwd_q;
  logic             last_q;
  logic [OFS_W-1:0] ofs_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] fwd_data_q;
  logic [OFS_W-1:0] word;
  logic             accept;

  assign accept = active_q & rsp_valid & ~start;

  refill_order #(.OFS_W(OFS_W)) u_order (
    .policy (pol_q),
    .crit   (crit_q),
    .step   (step_q),
    .word   (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      step_q   <= '0;
      we_q     <= 1'b0;
      fwd_q    <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      we_q   <= accept;
      fwd_q  <= accept && (word == crit_q);
      last_q <= accept && (step_q == LAST);
      if (start) begin
        active_q <= 1'b1;
        step_q   <= '0;
      end else if (accept) begin
        if (step_q == LAST) active_q <= 1'b0;
        step_q <= step_q + 1'b1;
      end
    end
  end

  // data path without reset so it maps onto plain flops / RAM write registers
  always_ff @(posedge clk) begin
    if (start) begin
      blk_q  <= blk;
      crit_q <= crit;
      pol_q  <= policy;
    end
    if (accept) begin
      ofs_q  <= word;
      data_q <= rsp_data;
      if (word == crit_q) fwd_data_q <= rsp_data;
    end
  end

  assign wr_en     = we_q;
  assign wr_blk    = blk_q;
  assign wr_ofs    = ofs_q;
  assign wr_data   = data_q;
  assign fwd_valid = fwd_q;
  assign fwd_data  = fwd_data_q;
  assign last_wr   = last_q;

endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl
  import refill_pkg::*;
#(
  parameter int BLK_W  = 28,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          miss_valid,
  output logic                          miss_ready,
  input  logic [BLK_W-1:0]              miss_blk,
  input  logic [$clog2(WORDS)-1:0]      miss_ofs,
  input  logic                          miss_crit_first,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [BLK_W+$clog2(WORDS)-1:0] mem_req_addr,
  input  logic                          mem_rsp_valid,
  input  logic [DATA_W-1:0]             mem_rsp_data,
  output logic                          arr_we,
  output logic [BLK_W-1:0]              arr_blk,
  output logic [$clog2(WORDS)-1:0]      arr_ofs,
  output logic [DATA_W-1:0]             arr_wdata,
  output logic                          cpu_valid,
  output logic [DATA_W-1:0]             cpu_data,
  output logic                          fill_done,
  output logic [BLK_W-1:0]              fill_blk
);

  logic        busy_q;
  logic        done_q;
  logic [BLK_W-1:0] fill_blk_q;
  logic        start;
  logic        last_wr;
  fill_order_e policy;

  assign start  = miss_valid & ~busy_q;
  assign policy = fill_order_e'(miss_crit_first);

  refill_issue #(.BLK_W(BLK_W), .WORDS(WORDS)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .blk       (miss_blk),
    .crit      (miss_ofs),
    .policy    (policy),
    .req_ready (mem_req_ready),
    .req_valid (mem_req_valid),
    .req_addr  (mem_req_addr)
  );

  refill_collect #(.BLK_W(BLK_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_collect (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .blk       (miss_blk),
    .crit      (miss_ofs),
    .policy    (policy),
    .rsp_valid (mem_rsp_valid),
    .rsp_data  (mem_rsp_data),
    .wr_en     (arr_we),
    .wr_blk    (arr_blk),
    .wr_ofs    (arr_ofs),
    .wr_data   (arr_wdata),
    .fwd_valid (cpu_valid),
    .fwd_data  (cpu_data),
    .last_wr   (last_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_wr;
      if (start)        busy_q <= 1'b1;
      else if (last_wr) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (last_wr) fill_blk_q <= arr_blk;
  end

  assign miss_ready = ~busy_q;
  assign fill_done  = done_q;
  assign fill_blk   = fill_blk_q;

endmodule

// File: rtl/refill_ctrl_chk.sv
module refill_ctrl_chk #(
  parameter int BLK_W  = 28,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           miss_valid,
  input logic                           miss_ready,
  input logic                           mem_req_valid,
  input logic                           mem_req_ready,
  input logic [BLK_W+$clog2(WORDS)-1:0] mem_req_addr,
  input logic                           arr_we,
  input logic                           cpu_valid,
  input logic                           fill_done
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (miss_ready && !mem_req_valid && !arr_we && !cpu_valid && !fill_done));

  assert_no_req_idle_R2: assert property (@(posedge clk) disable iff (rst)
    miss_ready |-> !mem_req_valid);

  assert_fwd_single_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_valid |=> !cpu_valid);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    fill_done |=> !fill_done);

  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> $past(arr_we));

  assert_busy_after_take_R8: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready) |=> !miss_ready);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    miss_ready |-> (!arr_we && !cpu_valid));

endmodule

bind line_refill_ctrl refill_ctrl_chk #(.BLK_W(BLK_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_chk (.*);

// File: tb/sim_line_refill_ctrl.sv
module sim_line_refill_ctrl;

  localparam int BLK_W  = 28;
  localparam int DATA_W = 32;
  localparam int WORDS  = 4;
  localparam int OFS_W  = 2;
  localparam int AW     = BLK_W + OFS_W;
  localparam int NMISS  = 80;
  localparam int LIMIT  = 100000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              miss_valid = 1'b0;
  logic              miss_ready;
  logic [BLK_W-1:0]  miss_blk = '0;
  logic [OFS_W-1:0]  miss_ofs = '0;
  logic              miss_crit_first = 1'b0;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [AW-1:0]     mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic              arr_we;
  logic [BLK_W-1:0]  arr_blk;
  logic [OFS_W-1:0]  arr_ofs;
  logic [DATA_W-1:0] arr_wdata;
  logic              cpu_valid;
  logic [DATA_W-1:0] cpu_data;
  logic              fill_done;
  logic [BLK_W-1:0]  fill_blk;

  always #10 clk = ~clk;

  line_refill_ctrl #(.BLK_W(BLK_W), .DATA_W(DATA_W), .WORDS(WORDS)) u0 (.*);

  int nchk = 0;
  int nfail = 0;

  // bench model state
  bit               busy_m = 0;
  logic [BLK_W-1:0] cur_blk;
  logic [OFS_W-1:0] cur_ofs;
  bit               cur_cwf;
  int               req_idx, wr_idx, misses_issued, misses_done;
  logic [AW-1:0]    q [0:7];
  int               qh, qt, qn;
  bit               exp_we, exp_cpu, exp_done, done_next;
  logic [OFS_W-1:0] exp_wofs;
  logic [DATA_W-1:0] exp_wdata;
  bit               prev_hold;
  logic [AW-1:0]    prev_addr;
  int               rdy_pct, rsp_pct;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  function automatic logic [OFS_W-1:0] exp_word(input bit cwf, input logic [OFS_W-1:0] crit, input int k);
    int w;
    w = cwf ? (int'(crit) + k) % WORDS : k;
    return OFS_W'(w);
  endfunction

  function automatic logic [DATA_W-1:0] mem_word(input logic [AW-1:0] a, input int salt);
    return (DATA_W'(a) * 32'h9E3779B1) ^ DATA_W'(salt * 32'h01000193);
  endfunction

  task automatic step();
    logic [AW-1:0] ha;
    bit   drv_miss;
    // completion and ready (R7, R8)
    chk(fill_done == exp_done, "R7 fill_done timing", 64'(fill_done), 64'(exp_done));
    if (exp_done) begin
      chk(fill_blk == cur_blk, "R7 fill_blk", 64'(fill_blk), 64'(cur_blk));
      busy_m = 0;
      misses_done++;
    end
    chk(miss_ready == !busy_m, "R8 miss_ready", 64'(miss_ready), 64'(!busy_m));
    // array write (R5, R10)
    chk(arr_we == exp_we, "R5/R10 arr_we", 64'(arr_we), 64'(exp_we));
    done_next = 0;
    if (arr_we && exp_we) begin
      chk(arr_ofs == exp_wofs, "R5 arr_ofs", 64'(arr_ofs), 64'(exp_wofs));
      chk(arr_blk == cur_blk, "R5 arr_blk", 64'(arr_blk), 64'(cur_blk));
      chk(arr_wdata == exp_wdata, "R5 arr_wdata", 64'(arr_wdata), 64'(exp_wdata));
      wr_idx++;
      if (wr_idx == WORDS) done_next = 1;
    end
    // processor return (R6, R10)
    chk(cpu_valid == exp_cpu, "R6/R10 cpu_valid", 64'(cpu_valid), 64'(exp_cpu));
    if (cpu_valid && exp_cpu)
      chk(cpu_data == exp_wdata, "R6 cpu_data", 64'(cpu_data), 64'(exp_wdata));
    // held request (R9)
    if (prev_hold)
      chk(mem_req_valid && mem_req_addr == prev_addr, "R9 request held",
          64'(mem_req_addr), 64'(prev_addr));
    exp_done = done_next;
    exp_we = 0;
    exp_cpu = 0;
    drv_miss = 0;

    // response channel
    if (qn > 0 && ($urandom % 100) < rsp_pct) begin
      ha = q[qh];
      qh = (qh + 1) % 8;
      qn--;
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word(ha, misses_issued);
      exp_we    = 1;
      exp_wofs  = ha[OFS_W-1:0];
      exp_wdata = mem_rsp_data;
      exp_cpu   = (ha[OFS_W-1:0] == cur_ofs);
    end else if (!busy_m && ($urandom % 4) == 0) begin
      mem_rsp_valid = 1'b1;                 // stray response while idle (R10)
      mem_rsp_data  = $urandom;
    end else begin
      mem_rsp_valid = 1'b0;
    end

    // request channel (R2, R3, R4)
    mem_req_ready = (($urandom % 100) < rdy_pct);
    if (mem_req_valid) begin
      chk(busy_m && req_idx < WORDS, "R2 request count", 64'(req_idx), 64'(WORDS - 1));
      if (mem_req_ready && req_idx < WORDS) begin
        chk(mem_req_addr == {cur_blk, exp_word(cur_cwf, cur_ofs, req_idx)},
            cur_cwf ? "R3 wrap order address" : "R4 linear order address",
            64'(mem_req_addr), 64'({cur_blk, exp_word(cur_cwf, cur_ofs, req_idx)}));
        q[qt] = mem_req_addr;
        qt = (qt + 1) % 8;
        qn++;
        req_idx++;
      end
    end
    prev_hold = mem_req_valid && !mem_req_ready;
    prev_addr = mem_req_addr;

    // miss channel (R8 ignore while busy)
    if (!busy_m && misses_issued < NMISS && mem_rsp_valid == 1'b0 && ($urandom % 3) != 0) begin
      drv_miss = 1;
      miss_valid = 1'b1;
      miss_blk   = BLK_W'($urandom);
      case (misses_issued)
        0: begin miss_crit_first = 1'b1; miss_ofs = 2'd3; end
        1: begin miss_crit_first = 1'b1; miss_ofs = 2'd0; end
        2: begin miss_crit_first = 1'b0; miss_ofs = 2'd3; end
        3: begin miss_crit_first = 1'b0; miss_ofs = 2'd0; end
        default: begin miss_crit_first = 1'($urandom); miss_ofs = OFS_W'($urandom); end
      endcase
      cur_blk = miss_blk;
      cur_ofs = miss_ofs;
      cur_cwf = miss_crit_first;
      req_idx = 0;
      wr_idx  = 0;
      busy_m  = 1;
      misses_issued++;
    end else if (busy_m && ($urandom % 4) == 0) begin
      miss_valid = 1'b1;                    // must be ignored (R8)
      miss_blk   = BLK_W'($urandom);
      miss_ofs   = OFS_W'($urandom);
      miss_crit_first = 1'($urandom);
    end else begin
      miss_valid = 1'b0;
    end
    if (!drv_miss && misses_issued >= NMISS / 2) begin
      rdy_pct = 100;
      rsp_pct = 100;
    end
  endtask

  initial begin
    int cyc;
    void'($urandom(32'd20240611));
    qh = 0; qt = 0; qn = 0;
    misses_issued = 0; misses_done = 0;
    req_idx = 0; wr_idx = 0;
    exp_we = 0; exp_cpu = 0; exp_done = 0; prev_hold = 0;
    cur_blk = '0; cur_ofs = '0; cur_cwf = 0;
    rdy_pct = 60; rsp_pct = 55;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(miss_ready == 1'b1, "R1 miss_ready in reset", 64'(miss_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    chk(arr_we == 1'b0, "R1 arr_we in reset", 64'(arr_we), 64'd0);
    chk(cpu_valid == 1'b0, "R1 cpu_valid in reset", 64'(cpu_valid), 64'd0);
    chk(fill_done == 1'b0, "R1 fill_done in reset", 64'(fill_done), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(miss_ready == 1'b1 && !mem_req_valid && !arr_we && !cpu_valid && !fill_done,
        "R1 state after reset", 64'(miss_ready), 64'd1);
    cyc = 0;
    while (misses_done < NMISS && cyc < LIMIT) begin
      step();
      @(negedge clk);
      cyc++;
    end
    if (cyc >= LIMIT) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", misses_done, NMISS);
    end else begin
      miss_valid = 1'b0;
      mem_rsp_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(miss_ready && !mem_req_valid && !arr_we, "R2 idle after last line",
          64'(mem_req_valid), 64'd0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule